// File: doc/BRIEF.md
# Overload Cycle Integrator with Restart Delay

This block guards a current-mode switching converter against sustained overload. At the end of every switching cycle the surrounding logic presents a one-clock strobe together with a flag that says whether that cycle was cut short by the peak current limit. The block keeps a bidirectional count of these outcomes. Cycles at the limit raise the count and normal cycles lower it. A brief overload therefore fades away. An overload that persists long enough pushes the count to a trip value, which stands for the overload time.

On a trip the block drops its switching enable and runs a restart delay measured in clock cycles. When the delay expires it raises the enable again and pulses a soft-start trigger for one clock, so the converter ramps its current limit back up. If the overload is still there, the same trip-and-wait pattern repeats. A wrapping fault counter advances once per trip.

Top module: `ovl_guard`

## Requirements
- R1: After reset `switchEn` is 1, `softStart` is 0 and `faultCount` is 0.
- R2: While `switchEn` is 1, a clock with `cycleEnd`=1 and `limitHit`=1 raises the internal count by one. If that count already stood at `TRIP_CYCLES`-1, the trip happens instead, and `switchEn` reads 0 from the next clock.
- R3: While `switchEn` is 1, a clock with `cycleEnd`=1 and `limitHit`=0 lowers the count by one, and leaves it at zero when it is already zero. Misses taken at zero therefore do not reduce the number of limit cycles needed to trip, which is `TRIP_CYCLES` from zero.
- R4: Limit and non-limit cycles net against each other. After a hits and b misses with b ≤ a, a trip needs `TRIP_CYCLES`-(a-b) further hits.
- R5: After a trip `switchEn` stays 0 for exactly `RESTART_CLKS` clock cycles and then returns to 1.
- R6: `softStart` is 1 for exactly one clock, and that clock is the first clock in which `switchEn` is 1 again after a restart delay. At no other time is `softStart` 1.
- R7: Strobes on `cycleEnd` while `switchEn` is 0 are ignored. This includes a strobe on the clock edge that ends the delay. Each trip clears the count, so after a restart a trip again needs `TRIP_CYCLES` limit cycles.
- R8: `faultCount` rises by exactly one on each trip and wraps to 0 after 2^`FAULT_W`-1.
- R9: Under a persistent overload, trip and restart repeat without limit. Each repetition takes `TRIP_CYCLES` limit cycles followed by the full restart delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleEnd | input | 1 | One-clock strobe marking the end of a switching cycle |
| limitHit | input | 1 | Qualifies `cycleEnd`: 1 when that cycle ended at the peak current limit |
| switchEn | output | 1 | Permission for the power switch to turn on |
| softStart | output | 1 | One-clock request to restart the current ramp |
| faultCount | output | FAULT_W | Wrapping count of trips |

## Verification
Two things can land on the same clock edge: the restart delay running out, and a cycle-end strobe that carries a limit hit. The bench provokes this by holding the strobe high on exactly the clock that ends the delay. It also sends extra strobes inside the delay. It then judges the outcome at the ports. The strobe must not be counted, so exactly `TRIP_CYCLES`-1 further hits must leave `switchEn` high, and one more hit must trip. Trip detection and the count update also share an edge: the hit that reaches the trip value must clear the count rather than raise it. This is confirmed by the spacing of the repeated trips.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } ovlState_t;

  typedef struct packed {
    logic cntUp;
    logic cntDown;
    logic cntClr;
    logic tmrLoad;
    logic tmrRun;
    logic faultBump;
  } ovlStrobe_t;

endpackage

// File: rtl/ovl_datapath.sv
module ovl_datapath
  import ovl_pkg::*;
#(
  parameter int TRIP_CYCLES  = 3000,
  parameter int RESTART_CLKS = 1000000,
  parameter int FAULT_W      = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ovlStrobe_t         strb,
  output logic               atTrip,
  output logic               timerDone,
  output logic [FAULT_W-1:0] faultCount
);

  localparam int CNT_W = (TRIP_CYCLES > 2) ? $clog2(TRIP_CYCLES) : 1;
  localparam int TMR_W = (RESTART_CLKS > 2) ? $clog2(RESTART_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(TRIP_CYCLES - 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(RESTART_CLKS - 1);

  logic [CNT_W-1:0] ovlCount;
  logic [TMR_W-1:0] restartTmr;

  // Bidirectional overload integrator, floored at zero
  always_ff @(posedge clk) begin
    if (!rstN || strb.cntClr) begin
      ovlCount <= '0;
    end else if (strb.cntUp) begin
      ovlCount <= ovlCount + 1'b1;
    end else if (strb.cntDown && ovlCount != '0) begin
      ovlCount <= ovlCount - 1'b1;
    end
  end

  // Restart delay, counted in clocks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      restartTmr <= '0;
    end else if (strb.tmrLoad) begin
      restartTmr <= TMR_LOAD;
    end else if (strb.tmrRun && restartTmr != '0) begin
      restartTmr <= restartTmr - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultCount <= '0;
    end else if (strb.faultBump) begin
      faultCount <= faultCount + 1'b1;
    end
  end

  assign atTrip    = (ovlCount == CNT_TOP);
  assign timerDone = (restartTmr == '0);

  // R3: the count never goes below zero
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (ovlCount == '0 && strb.cntDown && !strb.cntUp && !strb.cntClr) |=> ovlCount == '0);

  // R2: the count never passes the trip value
  a_r2_bounded: assert property (@(posedge clk) disable iff (!rstN)
    ovlCount <= CNT_TOP);

  // R7: a trip leaves the count at zero
  a_r7_clear_on_trip: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntClr |=> ovlCount == '0);

  // R8: one step per trip
  a_r8_fault_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.faultBump |=> faultCount == FAULT_W'($past(faultCount) + 1'b1));

endmodule

// File: rtl/ovl_ctrl.sv
module ovl_ctrl
  import ovl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycleEnd,
  input  logic       limitHit,
  input  logic       atTrip,
  input  logic       timerDone,
  output ovlStrobe_t strb,
  output logic       switchEn,
  output logic       softStart
);

  ovlState_t state, nextState;

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_RUN: begin
        if (cycleEnd) begin
          if (limitHit) begin
            if (atTrip) begin
              strb.cntClr    = 1'b1;
              strb.tmrLoad   = 1'b1;
              strb.faultBump = 1'b1;
              nextState      = ST_HOLD;
            end else begin
              strb.cntUp = 1'b1;
            end
          end else begin
            strb.cntDown = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (timerDone) nextState = ST_RUN;
        else           strb.tmrRun = 1'b1;
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_RUN;
      softStart <= 1'b0;
    end else begin
      state     <= nextState;
      softStart <= (state == ST_HOLD) && timerDone;
    end
  end

  assign switchEn = (state == ST_RUN);

  // R2: a hit at the trip value disables switching on the next clock
  a_r2_trip_disables: assert property (@(posedge clk) disable iff (!rstN)
    (switchEn && cycleEnd && limitHit && atTrip) |=> !switchEn);

  // R5: the hold persists while the delay is still running
  a_r5_hold_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (!switchEn && !timerDone) |=> !switchEn);

  // R6: the soft-start pulse accompanies the return of switching
  a_r6_ss_on_exit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(switchEn) |-> softStart);

  // R6: the pulse lasts a single clock
  a_r6_ss_single: assert property (@(posedge clk) disable iff (!rstN)
    softStart |=> !softStart);

  // R7: no count activity while switching is held off
  a_r7_ignore_in_hold: assert property (@(posedge clk) disable iff (!rstN)
    !switchEn |-> !(strb.cntUp || strb.cntDown || strb.faultBump));

endmodule

// File: rtl/ovl_guard.sv
module ovl_guard
  import ovl_pkg::*;
#(
  parameter int TRIP_CYCLES  = 3000,
  parameter int RESTART_CLKS = 1000000,
  parameter int FAULT_W      = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cycleEnd,
  input  logic               limitHit,
  output logic               switchEn,
  output logic               softStart,
  output logic [FAULT_W-1:0] faultCount
);

  ovlStrobe_t strb;
  logic       atTrip;
  logic       timerDone;

  ovl_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cycleEnd  (cycleEnd),
    .limitHit  (limitHit),
    .atTrip    (atTrip),
    .timerDone (timerDone),
    .strb      (strb),
    .switchEn  (switchEn),
    .softStart (softStart)
  );

  ovl_datapath #(
    .TRIP_CYCLES  (TRIP_CYCLES),
    .RESTART_CLKS (RESTART_CLKS),
    .FAULT_W      (FAULT_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .atTrip     (atTrip),
    .timerDone  (timerDone),
    .faultCount (faultCount)
  );

endmodule

// File: tb/ovl_guard_tb_top.sv
module ovl_guard_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TRIP       = 8;
  localparam int REST       = 20;
  localparam int FW         = 3;

  typedef struct {
    string  req;
    logic   en;
    logic   ss;
    int     fc;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cycleEnd = 1'b0;
  logic          limitHit = 1'b0;
  logic          switchEn;
  logic          softStart;
  logic [FW-1:0] faultCount;

  expItem_t expQ[$];
  event     chkEv;
  int       checks = 0;
  int       errors = 0;
  bit       finished = 0;
  int       mCount = 0;
  int       mFault = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovl_guard #(.TRIP_CYCLES(TRIP), .RESTART_CLKS(REST), .FAULT_W(FW)) dut_i (
    .clk(clk), .rstN(rstN), .cycleEnd(cycleEnd), .limitHit(limitHit),
    .switchEn(switchEn), .softStart(softStart), .faultCount(faultCount)
  );

  // Monitor: pops expectations and compares them with the ports
  initial begin
    forever begin
      @(chkEv);
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (switchEn !== it.en || softStart !== it.ss || int'(faultCount) != it.fc) begin
          errors++;
          $display("FAIL %s: en=%0b ss=%0b fc=%0d expected en=%0b ss=%0b fc=%0d",
                   it.req, switchEn, softStart, faultCount, it.en, it.ss, it.fc);
        end
      end
    end
  end

  task automatic expectNow(string req, logic en, logic ss);
    expItem_t it;
    it.req = req; it.en = en; it.ss = ss; it.fc = mFault % (1 << FW);
    expQ.push_back(it);
    ->chkEv;
    #1;
  endtask

  // One switching cycle; returns through model whether it tripped
  task automatic swCycle(bit hit, string req, output bit tripped);
    @(negedge clk);
    cycleEnd = 1'b1; limitHit = hit;
    @(negedge clk);
    cycleEnd = 1'b0; limitHit = 1'b0;
    tripped = 0;
    if (hit) begin
      if (mCount == TRIP - 1) begin
        tripped = 1; mCount = 0; mFault++;
      end else mCount++;
    end else if (mCount > 0) mCount--;
    expectNow(req, !tripped, 1'b0);
  endtask

  // Runs out the restart delay; starts at the negedge right after a trip
  task automatic restartSeq(bit noise, string req);
    for (int k = 1; k <= REST - 1; k++) begin
      cycleEnd = noise; limitHit = noise;
      @(negedge clk);
      expectNow(req, 1'b0, 1'b0);
    end
    cycleEnd = noise; limitHit = 1'b1;   // strobe on the exit edge (R7)
    @(negedge clk);
    cycleEnd = 1'b0; limitHit = 1'b0;
    expectNow("R6", 1'b1, 1'b1);
    @(negedge clk);
    expectNow("R6", 1'b1, 1'b0);
    mCount = 0;
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
          errors++;
          $display("FAIL watchdog: run did not complete, expected completion");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none
  end

  initial begin
    bit t;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expectNow("R1", 1'b1, 1'b0);

    // R3: misses at zero, then exactly TRIP hits needed
    for (int i = 0; i < 5; i++) swCycle(1'b0, "R3", t);
    for (int i = 0; i < TRIP - 1; i++) swCycle(1'b1, "R3", t);
    swCycle(1'b1, "R2", t);
    if (!t) begin errors++; $display("FAIL R2: tripped=0 expected 1"); end
    checks++;
    restartSeq(1'b0, "R5");

    // R4: hits and misses net against each other
    for (int i = 0; i < 6; i++) swCycle(1'b1, "R4", t);
    for (int i = 0; i < 4; i++) swCycle(1'b0, "R4", t);
    for (int i = 0; i < TRIP - 3; i++) swCycle(1'b1, "R4", t);
    swCycle(1'b1, "R4", t);
    restartSeq(1'b1, "R7");   // strobes during the hold are ignored

    // R7: after restart a full TRIP hits are again required
    for (int i = 0; i < TRIP - 1; i++) swCycle(1'b1, "R7", t);
    swCycle(1'b1, "R7", t);

    // R9 / R8: persistent overload, fault count wraps
    for (int n = 0; n < 7; n++) begin
      restartSeq(1'b0, "R9");
      for (int i = 0; i < TRIP; i++) swCycle(1'b1, "R8", t);
    end
    restartSeq(1'b0, "R9");
    expectNow("R8", 1'b1, 1'b0);

    @(negedge clk);
    #1;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule